// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit reads one bit out of a 16-bit or 32-bit data word and reports it on a carry output. It can also return the word with that bit changed. A bit index picks the position. A 2-bit mode picks what happens to the bit: leave it, clear it, set it or invert it. The carry always holds the bit as it was before any change. The unit acts as one execution slice beside a datapath. It takes one operation per cycle under a valid strobe and registers every result.

A size select chooses 16-bit or 32-bit operation. In 16-bit operation only the low half of the input word matters and only the low four index bits are used. The upper half of the result is returned as zero. Memory operands and bit offsets beyond the word are not handled here. The caller supplies a word that has already been fetched.

Top module: `bit_test_modify`

## Requirements
- R1: In every mode, `res_carry` equals the selected bit of the operand as it was before any change.
- R2: Mode 2'b00 (test only) returns the operand word unchanged on `res_word`.
- R3: Mode 2'b01 returns the operand with the selected bit forced to 0 and every other bit unchanged.
- R4: Mode 2'b10 returns the operand with the selected bit forced to 1 and every other bit unchanged.
- R5: Mode 2'b11 returns the operand with the selected bit inverted and every other bit unchanged.
- R6: With `op_wide` = 0 (16-bit size), only `op_index[3:0]` selects the bit and `op_word[31:16]` is ignored. `res_word[31:16]` is 0. With `op_wide` = 1 (32-bit size), `op_index[4:0]` selects the bit.
- R7: Results appear on the first rising edge after the edge where `op_valid` is sampled high. `res_valid` is high for exactly that one cycle for each accepted operation.
- R8: In a cycle where `op_valid` is low, `res_word` and `res_carry` keep their previous values, whatever the other inputs do, and `res_valid` goes low.
- R9: While `rst_n` is low at a rising edge, `res_valid`, `res_carry` and `res_word` clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_word | input | 32 | Operand word |
| op_index | input | 5 | Bit index |
| op_mode | input | 2 | 00 test, 01 clear, 10 set, 11 invert |
| op_wide | input | 1 | 1 = 32-bit size, 0 = 16-bit size |
| res_valid | output | 1 | Result valid, one cycle per operation |
| res_word | output | 32 | Resulting word |
| res_carry | output | 1 | Selected bit before modification |

## Verification
The embedded assertions check every cycle that `res_valid` follows the strobe by one cycle, that the registered carry matches the selected operand bit, that at most one bit ever differs between operand and result, that the test mode and idle cycles leave the word alone, and that the upper half is cleared for 16-bit size. They cannot show that the right bit changed in the right direction. The bench shows this by sweeping every mode against every index in both sizes. It also replays known worked examples and mixes in random operands. Its idle-cycle scenarios show that changing inputs without a strobe disturbs nothing.

// File: rtl/btm_pkg.sv
// Package: shared widths and the mode encoding for the bit test and modify unit.
// Assumes: the word width is a power of two and twice the narrow width.
package btm_pkg;
    localparam int WORD_W   = 32;
    localparam int NARROW_W = 16;

    typedef enum logic [1:0] {
        BT_TEST  = 2'b00,
        BT_CLEAR = 2'b01,
        BT_SET   = 2'b10,
        BT_FLIP  = 2'b11
    } btm_mode_e;
endpackage

// File: rtl/btm_operand.sv
// Module: btm_operand
// Picks the effective operand and bit index for the selected size.
// It masks the index down to the narrow width and clears the upper
// half of the word when 16-bit size is chosen.
// Assumes: NARROW_W divides WORD_W and both are powers of two.
module btm_operand #(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 16,
    localparam int IDX_W   = $clog2(WORD_W),
    localparam int NIDX_W  = $clog2(NARROW_W)
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic              wide,
    output logic [WORD_W-1:0] word_eff,
    output logic [IDX_W-1:0]  idx_eff
);
    // Index masking: narrow size keeps only the low index bits.
    always_comb begin
        if (wide) idx_eff = idx_in;
        else      idx_eff = {{(IDX_W-NIDX_W){1'b0}}, idx_in[NIDX_W-1:0]};
    end

    // Word lanes: the low lane always passes, upper lanes only in wide size.
    genvar gi;
    generate
        for (gi = 0; gi < WORD_W; gi++) begin : g_lane
            if (gi < NARROW_W) begin : g_low
                assign word_eff[gi] = word_in[gi];
            end else begin : g_high
                assign word_eff[gi] = word_in[gi] & wide;
            end
        end
    endgenerate
endmodule

// File: rtl/btm_bit_modify.sv
// Module: btm_bit_modify
// Combinational core: builds a one-hot mask from the index, extracts the
// selected bit as carry and forms the result word for the chosen mode.
// Assumes: the index is already masked to the active size.
module btm_bit_modify
    import btm_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    input  btm_mode_e         mode,
    output logic [WORD_W-1:0] word_out,
    output logic              carry
);
    logic [WORD_W-1:0] sel_mask;

    // One-hot decoder: a comparator per bit position.
    genvar gb;
    generate
        for (gb = 0; gb < WORD_W; gb++) begin : g_dec
            assign sel_mask[gb] = (idx == IDX_W'(gb));
        end
    endgenerate

    // Carry extract: OR-reduce the masked word.
    assign carry = |(word & sel_mask);

    // Write-back selection per mode.
    always_comb begin
        unique case (mode)
            BT_TEST:  word_out = word;
            BT_CLEAR: word_out = word & ~sel_mask;
            BT_SET:   word_out = word | sel_mask;
            BT_FLIP:  word_out = word ^ sel_mask;
            default:  word_out = word;
        endcase
    end
endmodule

// File: rtl/btm_out_reg.sv
// Module: btm_out_reg
// Output stage: captures the result under the strobe, holds it otherwise,
// and raises the valid flag for one cycle per captured result.
// Assumes: synchronous active-low reset.
module btm_out_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_d,
    input  logic              carry_d,
    output logic              valid_q,
    output logic [WORD_W-1:0] word_q,
    output logic              carry_q
);
    // Valid flag: follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= load;
    end

    // Result data: captured on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            carry_q <= 1'b0;
        end else if (load) begin
            word_q  <= word_d;
            carry_q <= carry_d;
        end
    end

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(word_q) && $stable(carry_q) && !valid_q));
endmodule

// File: rtl/bit_test_modify.sv
// Module: bit_test_modify (top)
// Tests one bit of a 16/32-bit word, copies it to a carry output and
// optionally clears, sets or inverts it; results are registered.
// Assumes: operands are already fetched; one operation per cycle at most.
module bit_test_modify
    import btm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid,
    input  logic [31:0] op_word,
    input  logic [4:0]  op_index,
    input  logic [1:0]  op_mode,
    input  logic        op_wide,
    output logic        res_valid,
    output logic [31:0] res_word,
    output logic        res_carry
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] word_eff;
    logic [IDX_W-1:0]  idx_eff;
    logic [WORD_W-1:0] word_new;
    logic              carry_new;
    btm_mode_e         mode_e;

    assign mode_e = btm_mode_e'(op_mode);

    btm_operand #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_operand (
        .word_in  (op_word),
        .idx_in   (op_index),
        .wide     (op_wide),
        .word_eff (word_eff),
        .idx_eff  (idx_eff)
    );

    btm_bit_modify #(.WORD_W(WORD_W)) u_modify (
        .word     (word_eff),
        .idx      (idx_eff),
        .mode     (mode_e),
        .word_out (word_new),
        .carry    (carry_new)
    );

    btm_out_reg #(.WORD_W(WORD_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (op_valid),
        .word_d  (word_new),
        .carry_d (carry_new),
        .valid_q (res_valid),
        .word_q  (res_word),
        .carry_q (res_carry)
    );

    p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    p_carry_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (res_carry == $past(word_eff[idx_eff])));
    p_test_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_mode == 2'b00) |=> (res_word == $past(word_eff)));
    p_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ($countones(res_word ^ $past(word_eff)) <= 1));
    p_narrow_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_wide) |=> (res_word[31:16] == 16'h0000));
endmodule

// File: tb/sim_bit_test_modify.sv
module sim_bit_test_modify;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_word = '0;
    logic [4:0]  op_index = '0;
    logic [1:0]  op_mode = '0;
    logic        op_wide = 1'b0;
    logic        res_valid;
    logic [31:0] res_word;
    logic        res_carry;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bit_test_modify u0 (.*);

    function automatic logic [32:0] model(input logic [31:0] w, input logic [4:0] i,
                                          input logic [1:0] m, input logic wd);
        logic [31:0] x;
        logic [4:0]  k;
        logic        c;
        x = wd ? w : {16'h0000, w[15:0]};
        k = wd ? i : {1'b0, i[3:0]};
        c = x[k];
        case (m)
            2'b01: x[k] = 1'b0;
            2'b10: x[k] = 1'b1;
            2'b11: x[k] = ~x[k];
            default: ;
        endcase
        return {c, x};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one operation at the falling edge; check just after the next rising edge.
    task automatic run_op(input logic [31:0] w, input logic [4:0] i, input logic [1:0] m,
                          input logic wd, input string req);
        logic [32:0] e;
        e = model(w, i, m, wd);
        @(negedge clk);
        op_valid = 1'b1; op_word = w; op_index = i; op_mode = m; op_wide = wd;
        @(posedge clk); #1;
        check({req, " word"}, res_word, e[31:0]);
        check("R1 carry", {31'd0, res_carry}, {31'd0, e[32]});
        check("R7 valid", {31'd0, res_valid}, 32'd1);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] hold_w;
        logic        hold_c;
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset valid", {31'd0, res_valid}, 32'd0);
        check("R9 reset word", res_word, 32'd0);
        check("R9 reset carry", {31'd0, res_carry}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed worked examples.
        run_op(32'h0000_03F0, 5'd7, 2'b11, 1'b0, "R5 flip b7");
        run_op(32'h0000_001E, 5'd1, 2'b11, 1'b0, "R5 flip b1");
        run_op(32'h0000_0189, 5'd1, 2'b10, 1'b0, "R4 set b1");
        run_op(32'h0000_1010, 5'd4, 2'b00, 1'b0, "R2 test b4");
        run_op(32'hFFFF_FFFF, 5'd31, 2'b01, 1'b1, "R3 clear b31");
        run_op(32'hABCD_0001, 5'd16, 2'b10, 1'b0, "R6 narrow idx wrap");

        // R7: valid lasts exactly one cycle.
        @(posedge clk); #1;
        check("R7 valid drop", {31'd0, res_valid}, 32'd0);

        // R8: idle cycles with moving inputs leave outputs unchanged.
        hold_w = res_word; hold_c = res_carry;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            op_word = $urandom; op_index = 5'($urandom); op_mode = 2'($urandom);
            op_wide = 1'($urandom);
            @(posedge clk); #1;
            check("R8 hold word", res_word, hold_w);
            check("R8 hold carry", {31'd0, res_carry}, {31'd0, hold_c});
        end

        // Sweep of all modes against every index in both sizes.
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 32; i++) begin
                run_op(32'h5A3C_96E1 ^ (32'h1 << i), 5'(i), 2'(m), 1'b1,
                       m == 0 ? "R2" : m == 1 ? "R3" : m == 2 ? "R4" : "R5");
            end
            for (int i = 0; i < 16; i++) begin
                run_op(32'hFFFF_0000 | (32'h1 << i), 5'(i + 16), 2'(m), 1'b0, "R6");
            end
        end

        // Constrained random with a fixed seed, some back-to-back.
        void'($urandom(32'd2024));
        for (int j = 0; j < 300; j++) begin
            logic [32:0] e;
            logic [31:0] w;
            logic [4:0]  i;
            logic [1:0]  m;
            logic        wd;
            w = $urandom; i = 5'($urandom); m = 2'($urandom); wd = 1'($urandom);
            e = model(w, i, m, wd);
            @(negedge clk);
            op_valid = 1'b1; op_word = w; op_index = i; op_mode = m; op_wide = wd;
            @(posedge clk); #1;
            check("R3 R4 R5 R6 random word", res_word, e[31:0]);
            check("R1 random carry", {31'd0, res_carry}, {31'd0, e[32]});
            if (j % 3 == 0) begin
                @(negedge clk); op_valid = 1'b0;
            end
        end
        @(negedge clk); op_valid = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule